// File: doc/BRIEF.md
# Prescaled Periodic Timer with Interrupt Flags

This block holds two independent 16-bit down-counters, each fed by its own clock prescaler. A channel counts from its reload value to zero and then reloads, so it raises a timeout event at a fixed rate. It also raises a compare event once per period, when the count equals a programmable compare value. Each event sets a sticky raw flag. A per-event enable mask decides which flags reach the single interrupt request output. Software clears a flag by writing a one to its bit in a dedicated clear register.

Software drives the block through a small synchronous register port: one write strobe, a word address and write data. Read data is a combinational function of the address. A typical sequence is as follows: stop the channel, program the reload, prescale and compare values, clear stale flags, unmask the wanted events, then set the channel's run bit.

Top module: `pretick_timer`

## Requirements
- R1: With prescale value P and reload value L, a running channel counts L+1 ticks per period. Its timeout flag first sets (L+1)*(P+1) clocks after the write that sets its run bit, and every later timeout follows the previous one by the same count.
- R2: The prescaler produces one counter tick every P+1 input clocks, where P is the programmed prescale value (0 gives a tick on every clock).
- R3: The compare flag of a channel sets on the tick where the count equals the compare value M (M not above L). The first occurrence is (L-M+1)*(P+1) clocks after the run bit is set.
- R4: A raw flag sets when its event occurs, whatever the state of its mask bit, and it stays set until it is cleared.
- R5: Masked status reads as raw status ANDed with the mask. The irq output is high exactly when at least one masked status bit is 1.
- R6: Writing 1 to a bit of the clear register clears that raw flag on the same edge. Bits written as 0 leave their flags unchanged.
- R7: If a clear and a new event for the same flag fall on the same clock edge, the flag remains set.
- R8: Word addresses: 0 run control (bit 0 channel A, bit 1 channel B), 1/2/3 channel A reload/prescale/compare, 4/5/6 channel B reload/prescale/compare, 7 mask, 8 raw status, 9 masked status, 10 clear (reads 0). In mask, raw, masked and clear, bit 0 is A timeout, bit 4 is A compare, bit 8 is B timeout and bit 11 is B compare. All other bits read 0.
- R9: While its run bit is 0, a channel raises no events and keeps its counter and prescaler at their programmed values. Setting the run bit again starts a complete period.
- R10: After reset every register reads 0, both channels are stopped and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request, high while any masked flag is set |

## Verification
The flag assertions assume that a clear pulse only comes from a write to the clear address. They also assume that an event and its clear interact on a single edge. The bench respects this by issuing at most one write per cycle and by driving every bus input half a cycle away from the sampling edge. The counter assertions compare the next count with the previous reload value. They therefore assume that reload values change only while a channel is stopped, and the bench programs every channel before setting its run bit. Compare values are kept at or below the reload value, so the compare event is reachable in each tested period.

// File: rtl/ptim_pkg.sv
`timescale 1ns/1ps
package ptim_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int CNT_W  = 16;
    localparam int PRE_W  = 8;
    localparam int NCH    = 2;
    localparam int EV_PER_CH = 2;
    localparam int NEV    = NCH * EV_PER_CH;

    // register word map, channel blocks of three words after control
    localparam int REGS_PER_CH = 3;
    localparam logic [ADDR_W-1:0] ADR_RUN   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_MASK  = ADDR_W'(1 + REGS_PER_CH * NCH);
    localparam logic [ADDR_W-1:0] ADR_RAW   = ADDR_W'(2 + REGS_PER_CH * NCH);
    localparam logic [ADDR_W-1:0] ADR_MSTAT = ADDR_W'(3 + REGS_PER_CH * NCH);
    localparam logic [ADDR_W-1:0] ADR_CLR   = ADDR_W'(4 + REGS_PER_CH * NCH);

    // event index e = 2*ch + is_compare
    localparam int EV_TIMEOUT = 0;
    localparam int EV_COMPARE = 1;

    function automatic logic [ADDR_W-1:0] ch_addr(input int ch, input int slot);
        return ADDR_W'(1 + REGS_PER_CH * ch + slot);
    endfunction

    // fixed status bit position of each event
    function automatic int ev_bit(input int e);
        case (e)
            0:       return 0;
            1:       return 4;
            2:       return 8;
            default: return 11;
        endcase
    endfunction
endpackage

// File: rtl/ptim_chan.sv
`timescale 1ns/1ps
module ptim_chan #(
    parameter int CNT_W = ptim_pkg::CNT_W,
    parameter int PRE_W = ptim_pkg::PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    input  logic [PRE_W-1:0] prescale,
    input  logic [CNT_W-1:0] compare,
    output logic             timeout_o,
    output logic             compare_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] pre;
    } chan_t;

    chan_t st_d, st_q;
    logic  tick;

    always_comb begin
        st_d      = st_q;
        tick      = run && (st_q.pre == '0);
        timeout_o = tick && (st_q.cnt == '0);
        compare_o = tick && (st_q.cnt == compare);
        if (!run) begin
            st_d.cnt = reload;
            st_d.pre = prescale;
        end else if (tick) begin
            st_d.pre = prescale;
            st_d.cnt = (st_q.cnt == '0) ? reload : st_q.cnt - CNT_W'(1);
        end else begin
            st_d.pre = st_q.pre - PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == $past(reload)) && (st_q.pre == $past(prescale)));

    // R2
    pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && st_q.pre != '0) |=> (st_q.pre == $past(st_q.pre) - PRE_W'(1)));

    // R1
    reload_after_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> (st_q.cnt == $past(reload)));
endmodule

// File: rtl/ptim_flags.sv
`timescale 1ns/1ps
module ptim_flags #(
    parameter int NEV = ptim_pkg::NEV
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] event_i,
    input  logic [NEV-1:0] clr_i,
    input  logic [NEV-1:0] mask_i,
    output logic [NEV-1:0] raw_o,
    output logic [NEV-1:0] masked_o,
    output logic           irq_o
);
    typedef struct packed {
        logic [NEV-1:0] raw;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d     = fl_q;
        fl_d.raw = (fl_q.raw & ~clr_i) | event_i;
        raw_o    = fl_q.raw;
        masked_o = fl_q.raw & mask_i;
        irq_o    = |masked_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    for (genvar e = 0; e < NEV; e++) begin : g_chk
        // R7
        event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            event_i[e] |=> raw_o[e]);
        // R6
        clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[e] && !event_i[e]) |=> !raw_o[e]);
        // R4
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_o[e] && !clr_i[e]) |=> raw_o[e]);
    end
endmodule

// File: rtl/ptim_regs.sv
`timescale 1ns/1ps
module ptim_regs
    import ptim_pkg::*;
#(
    parameter int DW = ptim_pkg::DATA_W,
    parameter int AW = ptim_pkg::ADDR_W,
    parameter int CW = ptim_pkg::CNT_W,
    parameter int PW = ptim_pkg::PRE_W,
    parameter int NC = ptim_pkg::NCH,
    parameter int NE = ptim_pkg::NEV
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    input  logic [NE-1:0]         raw_i,
    input  logic [NE-1:0]         masked_i,
    output logic [NC-1:0]         run_o,
    output logic [NC-1:0][CW-1:0] reload_o,
    output logic [NC-1:0][PW-1:0] prescale_o,
    output logic [NC-1:0][CW-1:0] compare_o,
    output logic [NE-1:0]         mask_o,
    output logic [NE-1:0]         clr_o
);
    typedef struct packed {
        logic [NC-1:0]         run;
        logic [NC-1:0][CW-1:0] reload;
        logic [NC-1:0][PW-1:0] prescale;
        logic [NC-1:0][CW-1:0] compare;
        logic [NE-1:0]         mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata;

    always_comb begin
        cfg_d     = cfg_q;
        clr_o     = '0;
        bus_rdata = '0;
        if (bus_we) begin
            if (bus_addr == ADR_RUN) cfg_d.run = bus_wdata[NC-1:0];
            for (int ch = 0; ch < NC; ch++) begin
                if (bus_addr == ch_addr(ch, 0)) cfg_d.reload[ch]   = bus_wdata[CW-1:0];
                if (bus_addr == ch_addr(ch, 1)) cfg_d.prescale[ch] = bus_wdata[PW-1:0];
                if (bus_addr == ch_addr(ch, 2)) cfg_d.compare[ch]  = bus_wdata[CW-1:0];
            end
            for (int e = 0; e < NE; e++) begin
                if (bus_addr == ADR_MASK) cfg_d.mask[e] = bus_wdata[ev_bit(e)];
                if (bus_addr == ADR_CLR)  clr_o[e]      = bus_wdata[ev_bit(e)];
            end
        end
        if (bus_addr == ADR_RUN) bus_rdata[NC-1:0] = cfg_q.run;
        for (int ch = 0; ch < NC; ch++) begin
            if (bus_addr == ch_addr(ch, 0)) bus_rdata = DW'(cfg_q.reload[ch]);
            if (bus_addr == ch_addr(ch, 1)) bus_rdata = DW'(cfg_q.prescale[ch]);
            if (bus_addr == ch_addr(ch, 2)) bus_rdata = DW'(cfg_q.compare[ch]);
        end
        for (int e = 0; e < NE; e++) begin
            if (bus_addr == ADR_MASK)  bus_rdata[ev_bit(e)] = cfg_q.mask[e];
            if (bus_addr == ADR_RAW)   bus_rdata[ev_bit(e)] = raw_i[e];
            if (bus_addr == ADR_MSTAT) bus_rdata[ev_bit(e)] = masked_i[e];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign run_o      = cfg_q.run;
    assign reload_o   = cfg_q.reload;
    assign prescale_o = cfg_q.prescale;
    assign compare_o  = cfg_q.compare;
    assign mask_o     = cfg_q.mask;

    // R6
    clr_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_o != '0) |-> (bus_we && bus_addr == ADR_CLR));
endmodule

// File: rtl/pretick_timer.sv
`timescale 1ns/1ps
module pretick_timer
    import ptim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [NCH-1:0]            run;
    logic [NCH-1:0][CNT_W-1:0] reload;
    logic [NCH-1:0][PRE_W-1:0] prescale;
    logic [NCH-1:0][CNT_W-1:0] compare;
    logic [NEV-1:0]            mask, clr, raw, masked, events;

    ptim_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .raw_i      (raw),
        .masked_i   (masked),
        .run_o      (run),
        .reload_o   (reload),
        .prescale_o (prescale),
        .compare_o  (compare),
        .mask_o     (mask),
        .clr_o      (clr)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        ptim_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run[ch]),
            .reload    (reload[ch]),
            .prescale  (prescale[ch]),
            .compare   (compare[ch]),
            .timeout_o (events[EV_PER_CH*ch + EV_TIMEOUT]),
            .compare_o (events[EV_PER_CH*ch + EV_COMPARE])
        );
    end

    ptim_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_i  (events),
        .clr_i    (clr),
        .mask_i   (mask),
        .raw_o    (raw),
        .masked_o (masked),
        .irq_o    (irq)
    );

    // R5
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    // R9
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run == '0) |-> (events == '0));
endmodule

// File: tb/pretick_timer_bench.sv
`timescale 1ns/1ps
module pretick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pretick_timer u_pretick_timer (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    localparam logic [3:0] A_RUN = 0, A_MASK = 7, A_RAW = 8, A_MST = 9, A_CLR = 10;
    localparam int NV = 6;
    localparam int V_CH [NV] = '{0, 0, 1, 1, 0, 1};
    localparam int V_LD [NV] = '{9, 3, 20, 5, 255, 0};
    localparam int V_PR [NV] = '{0, 3, 1, 15, 2, 4};
    localparam int V_MT [NV] = '{4, 3, 0, 2, 100, 0};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int tb_, mb_, t1, t2, m1, exp_t, exp_m, n;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        for (int a = 0; a <= 10; a++) begin
            rd(4'(a), v);
            check($sformatf("R10 reset addr %0d", a), v, 0);
        end
        check("R10 reset irq", {31'd0, irq}, 0);

        // vector table: R1 R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            wr(A_RUN, 0);
            wr(A_CLR, 32'hFFFF_FFFF);
            wr(A_MASK, 0);
            wr(4'(1 + 3*V_CH[i]), 32'(V_LD[i]));
            wr(4'(2 + 3*V_CH[i]), 32'(V_PR[i]));
            wr(4'(3 + 3*V_CH[i]), 32'(V_MT[i]));
            tb_ = (V_CH[i] == 0) ? 0 : 8;
            mb_ = (V_CH[i] == 0) ? 4 : 11;
            exp_t = (V_LD[i] + 1) * (V_PR[i] + 1);
            exp_m = (V_LD[i] - V_MT[i] + 1) * (V_PR[i] + 1);
            t1 = -1; t2 = -1; m1 = -1;
            wr(A_RUN, 32'(1) << V_CH[i]);
            for (n = 1; n < 2000 && t2 < 0; n++) begin
                @(posedge clk); @(negedge clk);
                bus_we = 1'b0;
                rd(A_RAW, v);
                if (m1 < 0 && v[mb_]) m1 = n;
                if (v[tb_]) begin
                    if (t1 < 0) begin
                        t1 = n;
                        bus_we = 1'b1; bus_addr = A_CLR; bus_wdata = 32'(1) << tb_;
                    end else if (n > t1 + 1) t2 = n;
                end
            end
            bus_we = 1'b0;
            check($sformatf("R1 R2 first timeout vec %0d", i), 32'(t1), 32'(exp_t));
            check($sformatf("R1 second period vec %0d", i), 32'(t2 - t1), 32'(exp_t));
            check($sformatf("R3 R4 compare vec %0d", i), 32'(m1), 32'(exp_m));
        end

        // all four events, mask clear
        wr(A_RUN, 0);
        wr(A_CLR, 32'hFFFF_FFFF);
        wr(A_MASK, 0);
        for (int r = 1; r <= 6; r++) wr(4'(r), 0);
        wr(A_RUN, 3);
        idle(3);
        wr(A_RUN, 0);
        rd(A_RAW, v);   check("R8 R4 raw positions", v, 32'h911);
        rd(A_MST, v);   check("R5 masked with no mask", v, 0);
        check("R5 irq with no mask", {31'd0, irq}, 0);
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, v);  check("R8 mask unused bits", v, 32'h911);
        rd(A_MST, v);   check("R5 masked all", v, 32'h911);
        wr(A_MASK, 32'h100);
        rd(A_MST, v);   check("R5 masked single", v, 32'h100);
        check("R5 irq single", {31'd0, irq}, 1);
        wr(A_CLR, 0);
        rd(A_RAW, v);   check("R6 zero write keeps flags", v, 32'h911);
        wr(A_CLR, 32'h100);
        rd(A_RAW, v);   check("R6 clear one flag", v, 32'h811);
        check("R5 irq after clear", {31'd0, irq}, 0);
        rd(A_CLR, v);   check("R8 clear reads zero", v, 0);

        // R7 clear collides with event (A fires every clock)
        wr(A_RUN, 1);
        idle(2);
        wr(A_CLR, 32'h1);
        rd(A_RAW, v);   check("R7 event beats clear", v & 32'h1, 1);
        wr(A_RUN, 0);
        wr(A_CLR, 32'h11);
        rd(A_RAW, v);   check("R6 clear when stopped", v & 32'h11, 0);

        // R9 stopped channel holds, restart gives full period
        wr(4, 3); wr(5, 0); wr(6, 3);
        wr(A_CLR, 32'hFFFF_FFFF);
        idle(40);
        rd(A_RAW, v);   check("R9 stopped no events", v, 0);
        wr(A_RUN, 2);
        idle(2);
        wr(A_RUN, 0);
        rd(A_RAW, v);   check("R9 partial period no timeout", v & 32'h100, 0);
        wr(A_RUN, 2);
        t1 = -1;
        for (n = 1; n < 100 && t1 < 0; n++) begin
            @(posedge clk); @(negedge clk);
            rd(A_RAW, v);
            if (v[8]) t1 = n;
        end
        check("R9 restart full period", 32'(t1), 4);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule